// File: doc/BRIEF.md
# Two-Port Semaphore Latch Bank

This block holds a small set of semaphore latches that two independent ports can reach. Software on each side gives each latch the meaning of one region of shared memory. To claim a region, a port writes 0 to that region's latch. It then reads the latch back and sees 0 if it holds the region, or 1 if it does not. An owner gives the region up by writing 1. The bank only stores and reports ownership. It never gates memory traffic, so the protocol is advisory and depends on both sides following it.

A request that arrives while the other port holds the latch is remembered as pending. The waiting port is handed the latch on the clock edge after the owner releases it, so it can poll the latch until it reads 0. When both ports claim the same free latch in the same cycle, the left port wins and the right port's claim stays pending.

Top module: `semaBankTop`

## Requirements
- R1: After reset every latch is free with no pending claims, and a read of any index from either port returns 1.
- R2: The read data output of a port is 1 whenever that port is not doing a read (chip-select and read strobe not both high). During a read it is 0 exactly when that port owns the addressed latch, and 1 otherwise.
- R3: A write of 0 to a free latch grants that latch to the writing port, and a read returns 0 from the next cycle on.
- R4: When both ports write 0 to the same free latch in the same cycle, the left port is granted and the right port's claim is kept as pending.
- R5: A write of 0 to a latch held by the other port is kept as pending. When the owner writes 1, the latch is free in the next cycle and is granted to the pending port on the cycle after that.
- R6: A write of 1 from a port that does not own the latch leaves the owner unchanged and withdraws that port's own pending claim. A write of 0 from the current owner changes nothing.
- R7: An access to one latch index never changes the ownership of any other index, and existing ownership persists while no port writes.
- R8: Strobes with chip-select low are ignored, and reads have no side effect on any latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Asynchronous active-low reset |
| lCs | input | 1 | Left port chip-select |
| lAddr | input | 3 | Left port latch index |
| lWr | input | 1 | Left port write strobe |
| lRd | input | 1 | Left port read strobe |
| lWrData | input | 1 | Left write value: 0 claims, 1 releases |
| lRdData | output | 1 | Left read value: 0 means the left port owns the latch |
| rCs | input | 1 | Right port chip-select |
| rAddr | input | 3 | Right port latch index |
| rWr | input | 1 | Right port write strobe |
| rRd | input | 1 | Right port read strobe |
| rWrData | input | 1 | Right write value: 0 claims, 1 releases |
| rRdData | output | 1 | Right read value: 0 means the right port owns the latch |

## Verification
The bench checks when a pending claim is granted after a release. A design that grants in the same cycle as the release, or never grants, shows the wrong read value in the cycle between. It drives simultaneous claims on a free latch, where a design with reversed priority or no tie-break would grant the right port or both ports. It also issues releases from the non-owner and a withdrawn pending claim. A design that lets a stray release free the latch, or keeps a stale claim, would hand the latch to the wrong port. Accesses with chip-select low and accesses to neighbouring indices are also checked, since faulty decode would disturb latches that were never addressed.

// File: rtl/semaPkg.sv
package semaPkg;
  // Per-latch decoded strobes from control to the datapath
  typedef struct packed {
    logic reqL;
    logic relL;
    logic reqR;
    logic relR;
  } semaStrobe_t;
endpackage

// File: rtl/semaCtrl.sv
module semaCtrl #(
  parameter int NUM_SEMA = 8,
  localparam int AW = $clog2(NUM_SEMA)
) (
  input  logic                                lCs,
  input  logic [AW-1:0]                       lAddr,
  input  logic                                lWr,
  input  logic                                lRd,
  input  logic                                lWrData,
  input  logic                                rCs,
  input  logic [AW-1:0]                       rAddr,
  input  logic                                rWr,
  input  logic                                rRd,
  input  logic                                rWrData,
  output semaPkg::semaStrobe_t [NUM_SEMA-1:0] strobes,
  output logic                                lRdEn,
  output logic                                rRdEn
);
  logic lWrEn, rWrEn;

  assign lWrEn = lCs & lWr;
  assign rWrEn = rCs & rWr;
  assign lRdEn = lCs & lRd;
  assign rRdEn = rCs & rRd;

  for (genvar i = 0; i < NUM_SEMA; i++) begin : gDecode
    localparam logic [AW-1:0] IDX = AW'(i);
    logic lHit, rHit;
    assign lHit = lWrEn && (lAddr == IDX);
    assign rHit = rWrEn && (rAddr == IDX);
    assign strobes[i].reqL = lHit & ~lWrData;
    assign strobes[i].relL = lHit &  lWrData;
    assign strobes[i].reqR = rHit & ~rWrData;
    assign strobes[i].relR = rHit &  rWrData;
  end
endmodule

// File: rtl/semaCell.sv
module semaCell (
  input  logic                 clk,
  input  logic                 rst_n,
  input  semaPkg::semaStrobe_t strobe,
  output logic                 ownL,
  output logic                 ownR
);
  logic busy, byRight, pendL, pendR;
  logic busyNext, byRightNext, pendLNext, pendRNext;
  logic relByOwner;

  assign ownL = busy & ~byRight;
  assign ownR = busy &  byRight;

  always_comb begin
    pendLNext   = (pendL | (strobe.reqL & ~ownL)) & ~strobe.relL;
    pendRNext   = (pendR | (strobe.reqR & ~ownR)) & ~strobe.relR;
    relByOwner  = (ownL & strobe.relL) | (ownR & strobe.relR);
    busyNext    = busy;
    byRightNext = byRight;
    if (relByOwner) begin
      busyNext = 1'b0;
    end else if (!busy) begin
      if (pendLNext) begin
        busyNext    = 1'b1;
        byRightNext = 1'b0;
        pendLNext   = 1'b0;
      end else if (pendRNext) begin
        busyNext    = 1'b1;
        byRightNext = 1'b1;
        pendRNext   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      byRight <= 1'b0;
      pendL   <= 1'b0;
      pendR   <= 1'b0;
    end else begin
      busy    <= busyNext;
      byRight <= byRightNext;
      pendL   <= pendLNext;
      pendR   <= pendRNext;
    end
  end
endmodule

// File: rtl/semaBank.sv
module semaBank #(
  parameter int NUM_SEMA = 8,
  localparam int AW = $clog2(NUM_SEMA)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  semaPkg::semaStrobe_t [NUM_SEMA-1:0] strobes,
  input  logic [AW-1:0]                       lAddr,
  input  logic [AW-1:0]                       rAddr,
  input  logic                                lRdEn,
  input  logic                                rRdEn,
  output logic                                lRdData,
  output logic                                rRdData,
  output logic [NUM_SEMA-1:0]                 ownL,
  output logic [NUM_SEMA-1:0]                 ownR
);
  for (genvar i = 0; i < NUM_SEMA; i++) begin : gCell
    semaCell uCell (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (strobes[i]),
      .ownL   (ownL[i]),
      .ownR   (ownR[i])
    );
  end

  assign lRdData = lRdEn ? ~ownL[lAddr] : 1'b1;
  assign rRdData = rRdEn ? ~ownR[rAddr] : 1'b1;
endmodule

// File: rtl/semaBankTop.sv
module semaBankTop #(
  parameter int NUM_SEMA = 8,
  localparam int AW = $clog2(NUM_SEMA)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lCs,
  input  logic [AW-1:0] lAddr,
  input  logic          lWr,
  input  logic          lRd,
  input  logic          lWrData,
  output logic          lRdData,
  input  logic          rCs,
  input  logic [AW-1:0] rAddr,
  input  logic          rWr,
  input  logic          rRd,
  input  logic          rWrData,
  output logic          rRdData
);
  semaPkg::semaStrobe_t [NUM_SEMA-1:0] strobes;
  logic                                lRdEn, rRdEn;
  logic [NUM_SEMA-1:0]                 ownL, ownR;

  semaCtrl #(.NUM_SEMA(NUM_SEMA)) uCtrl (
    .lCs(lCs), .lAddr(lAddr), .lWr(lWr), .lRd(lRd), .lWrData(lWrData),
    .rCs(rCs), .rAddr(rAddr), .rWr(rWr), .rRd(rRd), .rWrData(rWrData),
    .strobes(strobes), .lRdEn(lRdEn), .rRdEn(rRdEn)
  );

  semaBank #(.NUM_SEMA(NUM_SEMA)) uBank (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .lAddr(lAddr), .rAddr(rAddr), .lRdEn(lRdEn), .rRdEn(rRdEn),
    .lRdData(lRdData), .rRdData(rRdData), .ownL(ownL), .ownR(ownR)
  );
endmodule

// File: rtl/semaBankChk.sv
module semaBankChk #(
  parameter int NUM_SEMA = 8,
  localparam int AW = $clog2(NUM_SEMA)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                lCs,
  input logic [AW-1:0]       lAddr,
  input logic                lWr,
  input logic                lRd,
  input logic                lWrData,
  input logic                lRdData,
  input logic                rCs,
  input logic [AW-1:0]       rAddr,
  input logic                rWr,
  input logic                rRd,
  input logic                rWrData,
  input logic                rRdData,
  input logic [NUM_SEMA-1:0] ownL,
  input logic [NUM_SEMA-1:0] ownR
);
  logic lReq, rReq, lRel, rRel, anyWr, sameIdx;
  assign lReq    = lCs & lWr & ~lWrData;
  assign rReq    = rCs & rWr & ~rWrData;
  assign lRel    = lCs & lWr &  lWrData;
  assign rRel    = rCs & rWr &  rWrData;
  assign anyWr   = (lCs & lWr) | (rCs & rWr);
  assign sameIdx = (lAddr == rAddr);

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(lCs && lRd) |-> lRdData) and (!(rCs && rRd) |-> rRdData));

  assert_free_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lReq && !ownL[lAddr] && !ownR[lAddr]) |=> ownL[$past(lAddr)]);

  assert_left_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lReq && rReq && sameIdx && !ownL[lAddr] && !ownR[lAddr])
      |=> (ownL[$past(lAddr)] && !ownR[$past(lAddr)]));

  assert_release_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lRel && ownL[lAddr]) |=> (!ownL[$past(lAddr)] && !ownR[$past(lAddr)]));

  assert_stray_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rRel && ownL[rAddr] && !(lRel && sameIdx)) |=> ownL[$past(rAddr)]);

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !anyWr |=> (((~ownL & $past(ownL)) == '0) && ((~ownR & $past(ownR)) == '0)));
endmodule

bind semaBankTop semaBankChk #(.NUM_SEMA(NUM_SEMA)) uChk (
  .clk(clk), .rst_n(rst_n),
  .lCs(lCs), .lAddr(lAddr), .lWr(lWr), .lRd(lRd), .lWrData(lWrData), .lRdData(lRdData),
  .rCs(rCs), .rAddr(rAddr), .rWr(rWr), .rRd(rRd), .rWrData(rWrData), .rRdData(rRdData),
  .ownL(ownL), .ownR(ownR)
);

// File: tb/sim_semaBankTop.sv
module sim_semaBankTop;
  localparam int OP_IDLE = 0, OP_REQ = 1, OP_REL = 2, OP_READ = 3, OP_NOCS = 4;

  typedef struct {
    bit    val;
    string tag;
  } expItem_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lCs = 0, lWr = 0, lRd = 0, lWrData = 0;
  logic rCs = 0, rWr = 0, rRd = 0, rWrData = 0;
  logic [2:0] lAddr = 0, rAddr = 0;
  logic lRdData, rRdData;

  int applied = 0, miscompares = 0;
  bit done = 0;
  expItem_t qL[$], qR[$];

  always #2 clk = ~clk;

  semaBankTop u0 (
    .clk(clk), .rst_n(rst_n),
    .lCs(lCs), .lAddr(lAddr), .lWr(lWr), .lRd(lRd), .lWrData(lWrData), .lRdData(lRdData),
    .rCs(rCs), .rAddr(rAddr), .rWr(rWr), .rRd(rRd), .rWrData(rWrData), .rRdData(rRdData)
  );

  task automatic drivePort(input int op, input int a, output logic cs, output logic wr,
                           output logic rd, output logic wd, output logic [2:0] ad);
    cs = (op != OP_IDLE) && (op != OP_NOCS);
    wr = (op == OP_REQ) || (op == OP_REL) || (op == OP_NOCS);
    rd = (op == OP_READ);
    wd = (op == OP_REL);
    ad = 3'(a);
  endtask

  // One clock of stimulus; expected read values go into the scoreboard queues
  task automatic cyc(input int lop, input int la, input bit le,
                     input int rop, input int ra, input bit re, input string tag);
    logic cs, wr, rd, wd;
    logic [2:0] ad;
    @(posedge clk);
    #1;
    drivePort(lop, la, cs, wr, rd, wd, ad);
    lCs = cs; lWr = wr; lRd = rd; lWrData = wd; lAddr = ad;
    drivePort(rop, ra, cs, wr, rd, wd, ad);
    rCs = cs; rWr = wr; rRd = rd; rWrData = wd; rAddr = ad;
    if (lop == OP_READ) qL.push_back('{le, tag});
    if (rop == OP_READ) qR.push_back('{re, tag});
  endtask

  task automatic checkPort(input string side, input bit reading, input logic act,
                           ref expItem_t q[$]);
    expItem_t it;
    applied++;
    if (reading) begin
      if (q.size() == 0) begin
        miscompares++;
        $display("FAIL %s read with empty scoreboard, actual=%0b expected=none", side, act);
      end else begin
        it = q.pop_front();
        if (act !== it.val) begin
          miscompares++;
          $display("FAIL %s %s actual=%0b expected=%0b", it.tag, side, act, it.val);
        end
      end
    end else if (act !== 1'b1) begin
      miscompares++;
      $display("FAIL R2 %s idle output actual=%0b expected=1", side, act);
    end
  endtask

  // Monitor: compares at the falling edge, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !done) begin
        checkPort("left",  lCs && lRd, lRdData, qL);
        checkPort("right", rCs && rRd, rRdData, qR);
      end
    end
  end

  initial begin
    #(4 * 200000);
    miscompares++;
    $display("FAIL watchdog expired, actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: every latch free after reset
    for (int i = 0; i < 8; i++) cyc(OP_READ, i, 1, OP_READ, 7 - i, 1, "R1");

    // R3: claim of a free latch
    cyc(OP_REQ, 2, 0, OP_IDLE, 0, 0, "R3");
    cyc(OP_READ, 2, 0, OP_READ, 2, 1, "R3");

    // R5: right waits, left releases, grant one cycle after the free cycle
    cyc(OP_IDLE, 0, 0, OP_REQ, 2, 0, "R5");
    cyc(OP_READ, 2, 0, OP_READ, 2, 1, "R5");
    cyc(OP_REL, 2, 0, OP_IDLE, 0, 0, "R5");
    cyc(OP_READ, 2, 1, OP_READ, 2, 1, "R5");
    cyc(OP_READ, 2, 1, OP_READ, 2, 0, "R5");

    // R6: stray release, owner re-claim, withdrawn pending claim
    cyc(OP_REL, 2, 0, OP_IDLE, 0, 0, "R6");
    cyc(OP_READ, 2, 1, OP_READ, 2, 0, "R6");
    cyc(OP_REQ, 2, 0, OP_REQ, 2, 0, "R6");
    cyc(OP_REL, 2, 0, OP_READ, 2, 0, "R6");
    cyc(OP_IDLE, 0, 0, OP_REL, 2, 0, "R6");
    cyc(OP_IDLE, 0, 0, OP_IDLE, 0, 0, "R6");
    cyc(OP_READ, 2, 1, OP_READ, 2, 1, "R6");

    // R4: both claim the same free latch
    cyc(OP_REQ, 5, 0, OP_REQ, 5, 0, "R4");
    cyc(OP_READ, 5, 0, OP_READ, 5, 1, "R4");
    cyc(OP_REL, 5, 0, OP_IDLE, 0, 0, "R4");
    cyc(OP_IDLE, 0, 0, OP_IDLE, 0, 0, "R4");
    cyc(OP_READ, 5, 1, OP_READ, 5, 0, "R4");
    cyc(OP_IDLE, 0, 0, OP_REL, 5, 0, "R4");
    cyc(OP_READ, 5, 1, OP_READ, 5, 1, "R4");

    // R7: independent indices
    cyc(OP_REQ, 0, 0, OP_REQ, 7, 0, "R7");
    cyc(OP_READ, 0, 0, OP_READ, 0, 1, "R7");
    cyc(OP_READ, 7, 1, OP_READ, 7, 0, "R7");
    cyc(OP_READ, 1, 1, OP_READ, 6, 1, "R7");
    cyc(OP_IDLE, 0, 0, OP_IDLE, 0, 0, "R7");
    cyc(OP_READ, 0, 0, OP_READ, 7, 0, "R7");

    // R8: strobes without chip-select, reads without side effect
    cyc(OP_NOCS, 3, 0, OP_NOCS, 0, 0, "R8");
    cyc(OP_NOCS, 7, 0, OP_NOCS, 3, 0, "R8");
    cyc(OP_READ, 3, 1, OP_READ, 3, 1, "R8");
    cyc(OP_READ, 0, 0, OP_READ, 7, 0, "R8");
    cyc(OP_READ, 3, 1, OP_READ, 0, 1, "R8");
    cyc(OP_REL, 0, 0, OP_REL, 7, 0, "R8");
    cyc(OP_READ, 0, 1, OP_READ, 7, 1, "R8");
    cyc(OP_IDLE, 0, 0, OP_IDLE, 0, 0, "R8");

    @(posedge clk);
    @(negedge clk);
    done = 1;
    if (qL.size() != 0 || qR.size() != 0) begin
      miscompares++;
      $display("FAIL R2 unconsumed reads actual=%0d expected=0", qL.size() + qR.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule